// File: doc/BRIEF.md
# Call stack sequencer

This block saves and restores a return address on a byte-wide stack held in an internal data RAM. It is placed beside the fetch unit of a small processor core. When a call starts, the block works out the return address from the address of the call and its length. It writes that address to the stack as two bytes in successive cycles, then loads the program counter with the call target. When a return starts, it reads the two bytes back, moves the stack pointer down past them and loads the program counter with the restored address.

The stack grows upward. Before each byte is written, the pointer moves up by one, so the pointer always names the most recently written byte. The low byte goes in first and the high byte second, which puts the high byte at the top of the stack. A return from interrupt follows the same sequence as a plain return. In addition, it raises a one-cycle release strobe, which the interrupt logic uses to clear its in-progress state. Computing the call target and arbitrating interrupt priority are the job of neighbouring blocks.

Top module: `callstk_seq`

## Requirements
- R1: After reset the stack pointer reads 07h, the program counter reads 0000h, and busy, RAM write enable, PC load strobe and interrupt release strobe are all low.
- R2: A request accepted while idle raises busy in the next cycle, and busy stays high for exactly two cycles.
- R3: A call performs two RAM writes, one per busy cycle. The first goes to stack pointer + 1 and the second to stack pointer + 2, and the pointer finishes 2 above its start. Starting from 07h with a call at 0123h, this leaves 25h at 08h, 01h at 09h and the pointer at 09h.
- R4: The pushed return address is the call address + 2 when `call_long` is 0 and the call address + 3 when it is 1. Its low byte is written first and its high byte second.
- R5: In the cycle after the second write, `pc_out` equals the call target and `pc_load` is high for exactly that cycle. The interrupt release strobe stays low.
- R6: A return reads the high byte at the stack pointer in its first busy cycle and the low byte at stack pointer − 1 in its second, with no RAM write. In the next cycle it presents {high, low} on `pc_out` with `pc_load` high, and the pointer finishes 2 below its start.
- R7: A return-from-interrupt request behaves as a return and also pulses `irq_release` in the same cycle as `pc_load`. A plain return leaves `irq_release` low.
- R8: Call and return requests that arrive while busy are ignored. The operation in progress completes with its latched values, and no second operation starts.
- R9: When a call and a return are requested together while idle, the call is performed and the return is dropped.
- R10: The stack pointer wraps from FFh to 00h on a push and from 00h to FFh on a pop, with no indication.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| call_req | input | 1 | Start a call (sampled while idle) |
| ret_req | input | 1 | Start a subroutine return |
| reti_req | input | 1 | Start a return from interrupt |
| call_pc | input | 16 | Address of the call instruction |
| call_long | input | 1 | 0: two-byte call, 1: three-byte call |
| call_target | input | 16 | Destination loaded into the PC after a call |
| ram_addr | output | 8 | Internal RAM byte address |
| ram_wdata | output | 8 | Byte to write |
| ram_we | output | 1 | RAM write enable |
| ram_rdata | input | 8 | Byte read at `ram_addr` in the same cycle |
| sp_out | output | 8 | Current stack pointer |
| busy | output | 1 | A stack operation is in progress |
| pc_out | output | 16 | Program counter |
| pc_load | output | 1 | One-cycle strobe: `pc_out` has just been updated |
| irq_release | output | 1 | One-cycle strobe ending interrupt-in-progress |

## Verification
The assertions assume that the RAM returns the addressed byte combinationally in the same cycle, that no other master writes the stack region while an operation runs, and that request strobes are driven from registered logic. The bench meets these assumptions with a behavioural array that reads asynchronously and writes on the clock edge, driven only by the block. It changes every input on the falling edge. Its wrap sweep nests 127 calls, so 254 bytes cross the FFh boundary without overwriting any live entry. It then unwinds the stack in LIFO order.

// File: rtl/callstk_pkg.sv
`timescale 1ns/1ps
package callstk_pkg;
    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_PUSH_LO = 3'd1,
        ST_PUSH_HI = 3'd2,
        ST_POP_HI  = 3'd3,
        ST_POP_LO  = 3'd4
    } cs_state_e;
endpackage

// File: rtl/cs_retaddr.sv
`timescale 1ns/1ps
module cs_retaddr #(
    parameter int PC_W = 16
) (
    input  logic [PC_W-1:0] call_pc,
    input  logic            call_long,
    output logic [PC_W-1:0] ret_addr
);
    localparam logic [PC_W-1:0] SHORT_LEN = PC_W'(2);
    localparam logic [PC_W-1:0] LONG_LEN  = PC_W'(3);

    always_comb begin
        ret_addr = call_pc + (call_long ? LONG_LEN : SHORT_LEN);
    end
endmodule

// File: rtl/cs_sp_step.sv
`timescale 1ns/1ps
module cs_sp_step #(
    parameter int SP_W = 8
) (
    input  logic [SP_W-1:0] sp,
    output logic [SP_W-1:0] sp_up,
    output logic [SP_W-1:0] sp_down
);
    // modular arithmetic: wraps silently at both ends
    always_comb begin
        sp_up   = sp + SP_W'(1);
        sp_down = sp - SP_W'(1);
    end
endmodule

// File: rtl/callstk_seq.sv
`timescale 1ns/1ps
module callstk_seq #(
    parameter int          BYTE_W   = 8,
    parameter int          SP_W     = 8,
    parameter logic [7:0]  SP_RESET = 8'h07
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                call_req,
    input  logic                ret_req,
    input  logic                reti_req,
    input  logic [2*BYTE_W-1:0] call_pc,
    input  logic                call_long,
    input  logic [2*BYTE_W-1:0] call_target,
    output logic [SP_W-1:0]     ram_addr,
    output logic [BYTE_W-1:0]   ram_wdata,
    output logic                ram_we,
    input  logic [BYTE_W-1:0]   ram_rdata,
    output logic [SP_W-1:0]     sp_out,
    output logic                busy,
    output logic [2*BYTE_W-1:0] pc_out,
    output logic                pc_load,
    output logic                irq_release
);
    import callstk_pkg::*;

    localparam int PC_W = 2 * BYTE_W;
    localparam int HI_L = BYTE_W;

    typedef struct packed {
        cs_state_e       st;
        logic [SP_W-1:0] sp;
        logic [PC_W-1:0] save;
        logic [PC_W-1:0] target;
        logic [PC_W-1:0] pc;
        logic            pc_load;
        logic            irq_rel;
        logic            is_reti;
    } cs_regs_t;

    cs_regs_t        r_q, r_d;
    logic [PC_W-1:0] ret_addr_w;
    logic [SP_W-1:0] sp_up_w, sp_down_w;

    cs_retaddr #(.PC_W(PC_W)) u_retaddr (
        .call_pc   (call_pc),
        .call_long (call_long),
        .ret_addr  (ret_addr_w)
    );

    cs_sp_step #(.SP_W(SP_W)) u_sp_step (
        .sp      (r_q.sp),
        .sp_up   (sp_up_w),
        .sp_down (sp_down_w)
    );

    always_comb begin
        r_d         = r_q;
        r_d.pc_load = 1'b0;
        r_d.irq_rel = 1'b0;
        ram_addr    = r_q.sp;
        ram_wdata   = '0;
        ram_we      = 1'b0;
        case (r_q.st)
            ST_IDLE: begin
                if (call_req) begin
                    r_d.st     = ST_PUSH_LO;
                    r_d.save   = ret_addr_w;
                    r_d.target = call_target;
                end else if (ret_req || reti_req) begin
                    r_d.st      = ST_POP_HI;
                    r_d.is_reti = reti_req;
                end
            end
            ST_PUSH_LO: begin
                ram_addr  = sp_up_w;
                ram_wdata = r_q.save[BYTE_W-1:0];
                ram_we    = 1'b1;
                r_d.sp    = sp_up_w;
                r_d.st    = ST_PUSH_HI;
            end
            ST_PUSH_HI: begin
                ram_addr    = sp_up_w;
                ram_wdata   = r_q.save[PC_W-1:HI_L];
                ram_we      = 1'b1;
                r_d.sp      = sp_up_w;
                r_d.pc      = r_q.target;
                r_d.pc_load = 1'b1;
                r_d.st      = ST_IDLE;
            end
            ST_POP_HI: begin
                ram_addr               = r_q.sp;
                r_d.save[PC_W-1:HI_L]  = ram_rdata;
                r_d.sp                 = sp_down_w;
                r_d.st                 = ST_POP_LO;
            end
            ST_POP_LO: begin
                ram_addr    = r_q.sp;
                r_d.pc      = {r_q.save[PC_W-1:HI_L], ram_rdata};
                r_d.pc_load = 1'b1;
                r_d.irq_rel = r_q.is_reti;
                r_d.sp      = sp_down_w;
                r_d.st      = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st      <= ST_IDLE;
            r_q.sp      <= SP_W'(SP_RESET);
            r_q.save    <= '0;
            r_q.target  <= '0;
            r_q.pc      <= '0;
            r_q.pc_load <= 1'b0;
            r_q.irq_rel <= 1'b0;
            r_q.is_reti <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign sp_out      = r_q.sp;
    assign busy        = (r_q.st != ST_IDLE);
    assign pc_out      = r_q.pc;
    assign pc_load     = r_q.pc_load;
    assign irq_release = r_q.irq_rel;

    // R2
    busy_two_cycles_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |=> (busy ##1 !busy));

    // R3
    write_lands_at_sp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |=> (sp_out == $past(ram_addr)));

    // R4
    low_then_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_PUSH_LO) |=> (ram_we && ram_addr == SP_W'($past(ram_addr) + SP_W'(1))));

    // R6
    pop_moves_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_POP_HI) |=> (!ram_we && sp_out == SP_W'($past(sp_out) - SP_W'(1))));

    // R7
    release_with_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_release |-> pc_load);

    // R8
    load_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pc_load |-> !busy);

    // R9
    call_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && call_req) |=> (r_q.st == ST_PUSH_LO));
endmodule

// File: tb/tb_callstk_seq.sv
`timescale 1ns/1ps
module tb_callstk_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        call_req = 1'b0, ret_req = 1'b0, reti_req = 1'b0;
    logic [15:0] call_pc = '0, call_target = '0;
    logic        call_long = 1'b0;
    logic [7:0]  ram_addr, ram_wdata, ram_rdata, sp_out;
    logic        ram_we, busy, pc_load, irq_release;
    logic [15:0] pc_out;

    logic [7:0]  mem [256];
    logic [15:0] stk [256];
    int          depth = 0;
    logic [7:0]  sp_m = 8'h07;
    int          n_chk = 0, n_fail = 0;

    always #10 clk = ~clk;

    callstk_seq dut (
        .clk(clk), .rst_n(rst_n), .call_req(call_req), .ret_req(ret_req),
        .reti_req(reti_req), .call_pc(call_pc), .call_long(call_long),
        .call_target(call_target), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
        .ram_we(ram_we), .ram_rdata(ram_rdata), .sp_out(sp_out), .busy(busy),
        .pc_out(pc_out), .pc_load(pc_load), .irq_release(irq_release)
    );

    assign ram_rdata = mem[ram_addr];
    always @(posedge clk) if (ram_we) mem[ram_addr] <= ram_wdata;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_call(input logic [15:0] pc, input bit lng, input logic [15:0] tgt,
                           input bit spam, input bit with_ret);
        logic [15:0] ra = pc + (lng ? 16'd3 : 16'd2);
        @(negedge clk);
        call_pc = pc; call_long = lng; call_target = tgt; call_req = 1'b1; ret_req = with_ret;
        @(negedge clk);
        if (spam) begin
            call_pc = ~pc; call_target = ~tgt; call_long = ~lng;
            ret_req = 1'b1; reti_req = 1'b1;
        end else begin
            call_req = 1'b0; ret_req = 1'b0;
        end
        chk(busy == 1'b1, "R2 busy first cycle", busy, 1);
        chk(ram_we && ram_addr == 8'(sp_m + 1), "R3 first write addr", ram_addr, 8'(sp_m + 1));
        chk(ram_wdata == ra[7:0], "R4 low byte first", ram_wdata, ra[7:0]);
        @(negedge clk);
        chk(busy == 1'b1, "R2 busy second cycle", busy, 1);
        chk(ram_we && ram_addr == 8'(sp_m + 2), "R3 second write addr", ram_addr, 8'(sp_m + 2));
        chk(ram_wdata == ra[15:8], "R4 high byte second", ram_wdata, ra[15:8]);
        @(negedge clk);
        call_req = 1'b0; ret_req = 1'b0; reti_req = 1'b0;
        chk(busy == 1'b0, "R2 busy ends", busy, 0);
        chk(pc_load == 1'b1 && pc_out == tgt, "R5 pc loaded with target", pc_out, tgt);
        chk(irq_release == 1'b0, "R5 no release on call", irq_release, 0);
        sp_m = 8'(sp_m + 2);
        chk(sp_out == sp_m, "R3 sp after call", sp_out, sp_m);
        chk(mem[8'(sp_m - 1)] == ra[7:0] && mem[sp_m] == ra[15:8], "R4 stack image",
            {mem[sp_m], mem[8'(sp_m - 1)]}, ra);
        stk[depth] = ra; depth++;
        if (spam) begin
            @(negedge clk);
            chk(busy == 1'b0 && pc_load == 1'b0, "R8 no second operation", {busy, pc_load}, 0);
            chk(pc_out == tgt, "R8 latched target kept", pc_out, tgt);
        end
    endtask

    task automatic do_ret(input bit reti);
        logic [15:0] ra;
        depth--; ra = stk[depth];
        @(negedge clk);
        ret_req = ~reti; reti_req = reti;
        @(negedge clk);
        ret_req = 1'b0; reti_req = 1'b0;
        chk(busy && !ram_we && ram_addr == sp_m, "R6 read high at sp", ram_addr, sp_m);
        @(negedge clk);
        chk(busy && !ram_we && ram_addr == 8'(sp_m - 1), "R6 read low at sp-1", ram_addr, 8'(sp_m - 1));
        @(negedge clk);
        chk(pc_load == 1'b1 && pc_out == ra, "R6 restored pc", pc_out, ra);
        chk(irq_release == reti, "R7 release strobe", irq_release, reti);
        sp_m = 8'(sp_m - 2);
        chk(sp_out == sp_m, "R6 sp after return", sp_out, sp_m);
    endtask

    initial begin
        #(20 * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(sp_out == 8'h07, "R1 reset sp", sp_out, 8'h07);
        chk(pc_out == 16'h0000, "R1 reset pc", pc_out, 0);
        chk(!busy && !ram_we && !pc_load && !irq_release, "R1 reset strobes",
            {busy, ram_we, pc_load, irq_release}, 0);

        // documented example, then a long call
        do_call(16'h0123, 1'b0, 16'h0345, 1'b0, 1'b0);
        chk(mem[8'h08] == 8'h25 && mem[8'h09] == 8'h01, "R3 example image",
            {mem[8'h09], mem[8'h08]}, 16'h0125);
        do_call(16'h1000, 1'b1, 16'h2222, 1'b0, 1'b0);
        do_ret(1'b0);
        do_ret(1'b1);

        // requests while busy
        do_call(16'hABCD, 1'b1, 16'h4321, 1'b1, 1'b0);
        do_ret(1'b0);

        // simultaneous call and return while idle
        do_call(16'h7FFE, 1'b0, 16'h0F0F, 1'b0, 1'b1);
        do_ret(1'b1);

        // R10 wrap sweep: 127 nested calls cross FFh, then unwind
        for (int i = 0; i < 127; i++)
            do_call(16'(i * 16'h0203 + 16'h0111), i[0], 16'(i * 16'h0101), 1'b0, 1'b0);
        chk(sp_out == 8'h05, "R10 sp wrapped up", sp_out, 8'h05);
        for (int i = 0; i < 127; i++) do_ret(i[1]);
        chk(sp_out == 8'h07, "R10 sp wrapped back", sp_out, 8'h07);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule